// File: doc/BRIEF.md
# Test Access Port Controller

This block is the serial test port of a chip. It follows the sixteen-state test controller that steps on each rising edge of the test clock according to the mode-select input. It also holds the instruction register and turns the current instruction into mode controls for the pins and the boundary cell chain. The serial output and every strobe and mode output change only on the falling edge of the test clock. This gives a downstream device a full half period of setup time.

An instruction is shifted in least-significant bit first through the instruction path. It takes effect on the falling edge of the update state. Data scans then pass through one of three registers: the one-bit bypass stage, a 32-bit identification register, or the external boundary chain, whose serial output enters on `bsr_so`. The controller can be reset by an active-low asynchronous test reset or by an active-high power-on reset. It also resets when the mode-select input is held high for five clocks. Any of these leaves the identification instruction current, or bypass when no identification register is built.

Top module: `tap_ctrl`

## Requirements
- R1: While `trst_n` is low or `por` is high, the controller is asynchronously forced to the reset state. In that case `in_reset`=1, `tdo_en`=0, and `instr` holds the identification code (4'b0001), or all ones when HAS_ID=0.
- R2: Five consecutive rising edges with `tms`=1 reach the reset state from any state. Four such edges from Shift-DR do not.
- R3: State transitions follow the standard sixteen-state graph, decided by `tms` on each rising edge of `tck`. In particular, the Pause-DR/Exit2-DR loop returns to Shift-DR without a new capture.
- R4: In Capture-IR the instruction shift stage loads 4'b0001 (the two low bits are 01 and the upper bits are 0). This value comes out on `tdo` least-significant bit first.
- R5: The instruction is shifted from `tdi` least-significant bit first. `instr` and the mode outputs keep their old value through Exit1-IR and change on the falling edge in Update-IR.
- R6: When the identification code (4'b0001) is current, a data scan returns the 32-bit `ID_CODE`, whose bit 0 is 1, least-significant bit first. This also holds right after reset.
- R7: The bypass stage is one bit. It captures 0, and in Shift-DR `tdo` repeats `tdi` one clock later.
- R8: Every code other than 0000, 0001, 0010, 0100 and 0101, including all ones (which a floating, pulled-up `tdi` shifts in), selects bypass with all mode outputs low.
- R9: Code 0000 (external test) sets `bsr_sel`=1 and `pins_from_bsr`=1. Code 0010 (preload) sets `bsr_sel`=1 and `pins_from_bsr`=0. In both cases Shift-DR passes `bsr_so` to `tdo`.
- R10: Code 0100 (clamp) sets `pins_from_bsr`=1 with bypass as the data path. Code 0101 (high-impedance) sets `pins_highz`=1 with bypass as the data path.
- R11: `tdo_en` is 1 only in Shift-IR and Shift-DR. `tdo` and `tdo_en` are updated on the falling edge of `tck`.
- R12: Each of `capture_ir`, `shift_ir`, `update_ir`, `capture_dr`, `shift_dr` and `update_dr` is 1 exactly while the controller is in the matching state, registered on the falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous test reset, active low |
| por | input | 1 | Power-on reset, active high, asynchronous |
| tms | input | 1 | Mode select, sampled on rising `tck` |
| tdi | input | 1 | Serial data in (pulled up on the board) |
| bsr_so | input | 1 | Serial output of the external boundary chain |
| tdo | output | 1 | Serial data out, falling-edge registered |
| tdo_en | output | 1 | Output enable for `tdo` |
| in_reset | output | 1 | Controller is in Test-Logic-Reset |
| capture_ir | output | 1 | Capture-IR strobe |
| shift_ir | output | 1 | Shift-IR strobe |
| update_ir | output | 1 | Update-IR strobe |
| capture_dr | output | 1 | Capture-DR strobe |
| shift_dr | output | 1 | Shift-DR strobe |
| update_dr | output | 1 | Update-DR strobe |
| instr | output | IR_W (4) | Current instruction |
| bsr_sel | output | 1 | Boundary chain is the selected data register |
| pins_from_bsr | output | 1 | Pins driven from boundary cells |
| pins_highz | output | 1 | All pin outputs disabled |

## Verification
A table of instruction codes is walked. It covers every decoded code plus three unused ones and all ones. After each load, one 33-bit data scan with a mixed pattern tells the three data paths apart: bypass shows a leading 0 followed by the input delayed by one bit, identification shows the fixed code, and the boundary path shows the constant `bsr_so`. Each instruction load also reads out the captured 0001 and checks that the modes do not change before Update-IR. Directed sequences cover the Pause-DR loop, the four-versus-five mode-select escape, and asynchronous reset in the middle of a scan.

// File: rtl/tap_pkg.sv
package tap_pkg;
  typedef enum logic [3:0] {
    S_RESET, S_IDLE,
    S_DR_SEL, S_DR_CAP, S_DR_SH, S_DR_EX1, S_DR_PAU, S_DR_EX2, S_DR_UPD,
    S_IR_SEL, S_IR_CAP, S_IR_SH, S_IR_EX1, S_IR_PAU, S_IR_EX2, S_IR_UPD
  } tap_state_e;
endpackage

// File: rtl/tap_fsm.sv
module tap_fsm
  import tap_pkg::*;
(
  input  logic       tck,
  input  logic       rst,
  input  logic       tms,
  output tap_state_e state
);
  tap_state_e nxt;

  always_comb begin
    nxt = state;
    unique case (state)
      S_RESET:  nxt = tms ? S_RESET  : S_IDLE;
      S_IDLE:   nxt = tms ? S_DR_SEL : S_IDLE;
      S_DR_SEL: nxt = tms ? S_IR_SEL : S_DR_CAP;
      S_DR_CAP: nxt = tms ? S_DR_EX1 : S_DR_SH;
      S_DR_SH:  nxt = tms ? S_DR_EX1 : S_DR_SH;
      S_DR_EX1: nxt = tms ? S_DR_UPD : S_DR_PAU;
      S_DR_PAU: nxt = tms ? S_DR_EX2 : S_DR_PAU;
      S_DR_EX2: nxt = tms ? S_DR_UPD : S_DR_SH;
      S_DR_UPD: nxt = tms ? S_DR_SEL : S_IDLE;
      S_IR_SEL: nxt = tms ? S_RESET  : S_IR_CAP;
      S_IR_CAP: nxt = tms ? S_IR_EX1 : S_IR_SH;
      S_IR_SH:  nxt = tms ? S_IR_EX1 : S_IR_SH;
      S_IR_EX1: nxt = tms ? S_IR_UPD : S_IR_PAU;
      S_IR_PAU: nxt = tms ? S_IR_EX2 : S_IR_PAU;
      S_IR_EX2: nxt = tms ? S_IR_UPD : S_IR_SH;
      S_IR_UPD: nxt = tms ? S_DR_SEL : S_IDLE;
      default:  nxt = S_RESET;
    endcase
  end

  always_ff @(posedge tck or posedge rst)
    if (rst) state <= S_RESET;
    else     state <= nxt;

  // run of consecutive high mode-select edges, saturating at five
  logic [2:0] ones_q;
  always_ff @(posedge tck or posedge rst)
    if (rst)               ones_q <= 3'd0;
    else if (!tms)         ones_q <= 3'd0;
    else if (ones_q != 3'd5) ones_q <= ones_q + 3'd1;

  // R2
  five_ones_chk: assert property (@(posedge tck) disable iff (rst)
    (ones_q == 3'd5) |-> (state == S_RESET));

  // R3
  leave_reset_chk: assert property (@(posedge tck) disable iff (rst)
    (state == S_RESET && !tms) |=> (state == S_IDLE));
endmodule

// File: rtl/tap_ir.sv
module tap_ir
  import tap_pkg::*;
#(
  parameter int              IR_W       = 4,
  parameter bit              HAS_ID     = 1'b1,
  parameter logic [IR_W-1:0] OP_EXTEST  = IR_W'(0),
  parameter logic [IR_W-1:0] OP_IDCODE  = IR_W'(1),
  parameter logic [IR_W-1:0] OP_PRELOAD = IR_W'(2),
  parameter logic [IR_W-1:0] OP_CLAMP   = IR_W'(4),
  parameter logic [IR_W-1:0] OP_HIGHZ   = IR_W'(5)
) (
  input  logic            tck,
  input  logic            rst,
  input  logic            tdi,
  input  tap_state_e      state,
  output logic            ir_so,
  output logic [IR_W-1:0] instr,
  output logic            sel_id,
  output logic            sel_bsr,
  output logic            pins_from_bsr,
  output logic            pins_highz
);
  localparam logic [IR_W-1:0] CAP_PAT = IR_W'(1);
  localparam logic [IR_W-1:0] RST_OP  = HAS_ID ? OP_IDCODE : {IR_W{1'b1}};

  logic [IR_W-1:0] sr_q, hold_q;

  always_ff @(posedge tck or posedge rst)
    if (rst)                    sr_q <= CAP_PAT;
    else if (state == S_IR_CAP) sr_q <= CAP_PAT;
    else if (state == S_IR_SH)  sr_q <= {tdi, sr_q[IR_W-1:1]};

  always_ff @(negedge tck or posedge rst)
    if (rst)                    hold_q <= RST_OP;
    else if (state == S_RESET)  hold_q <= RST_OP;
    else if (state == S_IR_UPD) hold_q <= sr_q;

  logic is_ext, is_pre, is_clamp, is_hz, is_id;
  always_comb begin
    is_ext   = (hold_q == OP_EXTEST);
    is_pre   = (hold_q == OP_PRELOAD);
    is_clamp = (hold_q == OP_CLAMP);
    is_hz    = (hold_q == OP_HIGHZ);
    is_id    = HAS_ID && (hold_q == OP_IDCODE);
  end

  assign ir_so         = sr_q[0];
  assign instr         = hold_q;
  assign sel_id        = is_id;
  assign sel_bsr       = is_ext | is_pre;
  assign pins_from_bsr = is_ext | is_clamp;
  assign pins_highz    = is_hz;

  // R4
  ir_capture_chk: assert property (@(posedge tck) disable iff (rst)
    (state == S_IR_CAP) |=> (sr_q[1:0] == 2'b01));

  // R5
  hold_update_chk: assert property (@(posedge tck) disable iff (rst)
    !$stable(hold_q) |-> (state == S_IR_UPD || state == S_RESET));

  // R10
  mode_excl_chk: assert property (@(posedge tck) disable iff (rst)
    !(pins_highz && pins_from_bsr));
endmodule

// File: rtl/tap_dr.sv
module tap_dr
  import tap_pkg::*;
#(
  parameter bit          HAS_ID  = 1'b1,
  parameter int          ID_W    = 32,
  parameter logic [31:0] ID_CODE = 32'h1A5C_E0B3
) (
  input  logic       tck,
  input  logic       rst,
  input  logic       tdi,
  input  tap_state_e state,
  input  logic       sel_id,
  output logic       byp_so,
  output logic       id_so
);
  logic byp_q;
  always_ff @(posedge tck or posedge rst)
    if (rst)                    byp_q <= 1'b0;
    else if (state == S_DR_CAP) byp_q <= 1'b0;
    else if (state == S_DR_SH)  byp_q <= tdi;
  assign byp_so = byp_q;

  // R7
  byp_capture_chk: assert property (@(posedge tck) disable iff (rst)
    (state == S_DR_CAP) |=> (byp_q == 1'b0));

  generate
    if (HAS_ID) begin : g_id
      logic [ID_W-1:0] id_q;
      always_ff @(posedge tck or posedge rst)
        if (rst)                              id_q <= ID_CODE[ID_W-1:0];
        else if (sel_id && state == S_DR_CAP) id_q <= ID_CODE[ID_W-1:0];
        else if (sel_id && state == S_DR_SH)  id_q <= {tdi, id_q[ID_W-1:1]};
      assign id_so = id_q[0];

      // R6
      id_capture_chk: assert property (@(posedge tck) disable iff (rst)
        (sel_id && state == S_DR_CAP) |=> (id_q[0] == 1'b1));
    end else begin : g_noid
      assign id_so = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/tap_ctrl.sv
module tap_ctrl
  import tap_pkg::*;
#(
  parameter int              IR_W       = 4,
  parameter bit              HAS_ID     = 1'b1,
  parameter logic [31:0]     ID_CODE    = 32'h1A5C_E0B3,
  parameter logic [IR_W-1:0] OP_EXTEST  = IR_W'(0),
  parameter logic [IR_W-1:0] OP_IDCODE  = IR_W'(1),
  parameter logic [IR_W-1:0] OP_PRELOAD = IR_W'(2),
  parameter logic [IR_W-1:0] OP_CLAMP   = IR_W'(4),
  parameter logic [IR_W-1:0] OP_HIGHZ   = IR_W'(5)
) (
  input  logic            tck,
  input  logic            trst_n,
  input  logic            por,
  input  logic            tms,
  input  logic            tdi,
  input  logic            bsr_so,
  output logic            tdo,
  output logic            tdo_en,
  output logic            in_reset,
  output logic            capture_ir,
  output logic            shift_ir,
  output logic            update_ir,
  output logic            capture_dr,
  output logic            shift_dr,
  output logic            update_dr,
  output logic [IR_W-1:0] instr,
  output logic            bsr_sel,
  output logic            pins_from_bsr,
  output logic            pins_highz
);
  logic       rst;
  tap_state_e state;
  logic       ir_so, byp_so, id_so, sel_id;

  assign rst = !trst_n || por;

  tap_fsm u_fsm (.tck(tck), .rst(rst), .tms(tms), .state(state));

  tap_ir #(
    .IR_W(IR_W), .HAS_ID(HAS_ID), .OP_EXTEST(OP_EXTEST), .OP_IDCODE(OP_IDCODE),
    .OP_PRELOAD(OP_PRELOAD), .OP_CLAMP(OP_CLAMP), .OP_HIGHZ(OP_HIGHZ)
  ) u_ir (
    .tck(tck), .rst(rst), .tdi(tdi), .state(state), .ir_so(ir_so),
    .instr(instr), .sel_id(sel_id), .sel_bsr(bsr_sel),
    .pins_from_bsr(pins_from_bsr), .pins_highz(pins_highz)
  );

  tap_dr #(.HAS_ID(HAS_ID), .ID_CODE(ID_CODE)) u_dr (
    .tck(tck), .rst(rst), .tdi(tdi), .state(state), .sel_id(sel_id),
    .byp_so(byp_so), .id_so(id_so)
  );

  logic so_mux;
  always_comb begin
    so_mux = 1'b0;
    if (state == S_IR_SH)      so_mux = ir_so;
    else if (state == S_DR_SH) so_mux = bsr_sel ? bsr_so : (sel_id ? id_so : byp_so);
  end

  always_ff @(negedge tck or posedge rst)
    if (rst) begin
      tdo <= 1'b0; tdo_en <= 1'b0; in_reset <= 1'b1;
      capture_ir <= 1'b0; shift_ir <= 1'b0; update_ir <= 1'b0;
      capture_dr <= 1'b0; shift_dr <= 1'b0; update_dr <= 1'b0;
    end else begin
      tdo        <= so_mux;
      tdo_en     <= (state == S_IR_SH) || (state == S_DR_SH);
      in_reset   <= (state == S_RESET);
      capture_ir <= (state == S_IR_CAP);
      shift_ir   <= (state == S_IR_SH);
      update_ir  <= (state == S_IR_UPD);
      capture_dr <= (state == S_DR_CAP);
      shift_dr   <= (state == S_DR_SH);
      update_dr  <= (state == S_DR_UPD);
    end

  // R11
  tdo_en_chk: assert property (@(posedge tck) disable iff (rst)
    tdo_en |-> (state == S_IR_SH || state == S_DR_SH));

  // R12
  strobe_onehot_chk: assert property (@(posedge tck) disable iff (rst)
    $onehot0({capture_ir, shift_ir, update_ir, capture_dr, shift_dr, update_dr}));
endmodule

// File: tb/tap_ctrl_tb.sv
`timescale 1ns/100ps
module tap_ctrl_tb;
  localparam logic [31:0] ID = 32'h1A5C_E0B3;

  logic tck = 1'b0, trst_n = 1'b1, por = 1'b1, tms = 1'b1, tdi = 1'b1, bsr_so = 1'b1;
  logic tdo, tdo_en, in_reset, capture_ir, shift_ir, update_ir;
  logic capture_dr, shift_dr, update_dr, bsr_sel, pins_from_bsr, pins_highz;
  logic [3:0] instr;
  int n_chk = 0, n_fail = 0;

  always #2.5 tck = ~tck;

  tap_ctrl #(.ID_CODE(ID)) u_dut (
    .tck(tck), .trst_n(trst_n), .por(por), .tms(tms), .tdi(tdi), .bsr_so(bsr_so),
    .tdo(tdo), .tdo_en(tdo_en), .in_reset(in_reset), .capture_ir(capture_ir),
    .shift_ir(shift_ir), .update_ir(update_ir), .capture_dr(capture_dr),
    .shift_dr(shift_dr), .update_dr(update_dr), .instr(instr), .bsr_sel(bsr_sel),
    .pins_from_bsr(pins_from_bsr), .pins_highz(pins_highz)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one rising edge with the given inputs; returns just after the next falling edge
  task automatic step(input bit m, input bit d);
    tms = m; tdi = d;
    @(posedge tck); @(negedge tck); #1;
  endtask

  // from Run-Test/Idle back to Run-Test/Idle
  task automatic load_ir(input logic [3:0] code);
    logic [3:0] cap, prev;
    prev = instr;
    step(1, 1); step(1, 1); step(0, 1);
    chk(capture_ir == 1'b1, "R12 capture_ir", capture_ir, 1);
    step(0, 1);
    chk(shift_ir && tdo_en, "R11 shift_ir/tdo_en", {shift_ir, tdo_en}, 2'b11);
    for (int i = 0; i < 4; i++) begin
      cap[i] = tdo;
      step(i == 3, code[i]);
    end
    chk(cap == 4'b0001, "R4 captured IR", cap, 4'b0001);
    chk(instr == prev && !tdo_en, "R5 no change before update", instr, prev);
    step(1, 1);
    chk(update_ir == 1'b1, "R12 update_ir", update_ir, 1);
    chk(instr == code, "R5 instr after update", instr, code);
    step(0, 1);
  endtask

  task automatic scan_dr(input logic [32:0] din, output logic [32:0] dout);
    step(1, 1); step(0, 1);
    chk(capture_dr == 1'b1, "R12 capture_dr", capture_dr, 1);
    step(0, 1);
    chk(shift_dr == 1'b1, "R12 shift_dr", shift_dr, 1);
    for (int i = 0; i < 33; i++) begin
      dout[i] = tdo;
      step(i == 32, din[i]);
    end
    step(1, 1);
    chk(update_dr == 1'b1, "R12 update_dr", update_dr, 1);
    step(0, 1);
  endtask

  // {code[8:5], bsr_sel[4], pins_from_bsr[3], pins_highz[2], path[1:0]}; path 0=bypass 1=id 2=boundary
  localparam logic [8:0] VEC [9] = '{
    {4'h0, 1'b1, 1'b1, 1'b0, 2'd2},
    {4'h2, 1'b1, 1'b0, 1'b0, 2'd2},
    {4'h1, 1'b0, 1'b0, 1'b0, 2'd1},
    {4'h4, 1'b0, 1'b1, 1'b0, 2'd0},
    {4'h5, 1'b0, 1'b0, 1'b1, 2'd0},
    {4'hF, 1'b0, 1'b0, 1'b0, 2'd0},
    {4'h3, 1'b0, 1'b0, 1'b0, 2'd0},
    {4'h9, 1'b0, 1'b0, 1'b0, 2'd0},
    {4'hE, 1'b0, 1'b0, 1'b0, 2'd0}
  };

  initial begin
    repeat (2000) @(posedge tck);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [32:0] din, dout;
    din = 33'h1_C3A5_6E91;
    repeat (3) @(negedge tck);
    #1;
    // R1 reset state held by power-on reset
    chk(in_reset && !tdo_en && instr == 4'h1, "R1 por state", {in_reset, tdo_en, instr}, {2'b10, 4'h1});
    por = 1'b0;
    step(1, 1);
    chk(in_reset == 1'b1, "R3 stay in reset with tms=1", in_reset, 1);
    step(0, 1);
    chk(in_reset == 1'b0, "R3 reset to idle", in_reset, 0);
    // R6 identification selected straight after reset
    scan_dr(din, dout);
    chk(dout[31:0] == ID, "R6 id after reset", dout[31:0], ID);
    chk(ID[0] == 1'b1, "R6 id lsb", ID[0], 1);

    for (int v = 0; v < 9; v++) begin
      logic [8:0] e;
      e = VEC[v];
      load_ir(e[8:5]);
      chk({bsr_sel, pins_from_bsr, pins_highz} == e[4:2], "R8 R9 R10 modes",
          {bsr_sel, pins_from_bsr, pins_highz}, e[4:2]);
      scan_dr(din, dout);
      if (e[1:0] == 2'd0)
        chk(dout == {din[31:0], 1'b0}, "R7 R8 bypass path", dout, {din[31:0], 1'b0});
      else if (e[1:0] == 2'd1)
        chk(dout[31:0] == ID, "R6 id path", dout[31:0], ID);
      else
        chk(dout == {33{1'b1}}, "R9 boundary path", dout, {33{1'b1}});
    end

    // R3 pause loop inside a bypass scan
    load_ir(4'hF);
    step(1, 1); step(0, 1); step(0, 1);
    chk(tdo == 1'b0, "R7 bypass captured 0", tdo, 0);
    step(1, 1);
    step(0, 1);
    chk(!tdo_en && !shift_dr, "R11 pause has no drive", {tdo_en, shift_dr}, 0);
    step(1, 0);
    step(0, 0);
    chk(shift_dr && tdo_en && tdo == 1'b1, "R3 pause loop back to shift", {shift_dr, tdo_en, tdo}, 3'b111);

    // R2 four ones from Shift-DR do not reset, the fifth does
    step(1, 1); step(1, 1); step(1, 1); step(1, 1);
    chk(in_reset == 1'b0 && instr == 4'hF, "R2 four ones", {in_reset, instr}, {1'b0, 4'hF});
    step(1, 1);
    chk(in_reset == 1'b1 && instr == 4'h1, "R2 five ones", {in_reset, instr}, {1'b1, 4'h1});

    // R1 asynchronous test reset in the middle of Shift-DR
    step(0, 1);
    load_ir(4'h0);
    step(1, 1); step(0, 1); step(0, 1);
    chk(tdo_en == 1'b1, "R11 shift-dr enabled", tdo_en, 1);
    trst_n = 1'b0;
    #1;
    chk(in_reset && !tdo_en && instr == 4'h1 && !bsr_sel, "R1 async trst",
        {in_reset, tdo_en, instr}, {2'b10, 4'h1});
    @(negedge tck); #1;
    trst_n = 1'b1;
    step(0, 1);
    chk(in_reset == 1'b0, "R3 idle after trst", in_reset, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule